// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block places a small, fast word store between a processor port and a slower main-memory port. Main memory holds 64K words of 16 bits, reached by a 16-bit word address. The cache keeps 128 lines of 16 words each, which is 2048 words in total. Each line has a stored tag, a valid flag and a dirty flag. Every memory block can go to exactly one line, so deciding hit or miss takes a single tag compare.

The processor holds a request, with its address and write data, until `cpu_ready` is sampled high at a rising edge. A read hit finishes in the same cycle the request is presented. A miss stalls the processor while the controller moves whole 16-word blocks over the memory port. That port transfers one word for each request/ready handshake.

A parameter fixes the write policy at build time.
- Write-through sends every write to memory and does not allocate on a write miss.
- Write-back keeps writes in the cache, marks the line dirty, and copies the line out only when it is evicted.

A separate invalidate port drops a resident block after an external agent, such as a DMA engine, has changed its copy in memory.

Top module: `dm_cache`

## Requirements
- R1: A synchronous active-low reset clears every valid and dirty flag. While reset is held, or with no request pending, `cpu_ready` and `mem_req` are low. After reset, any earlier resident block misses.
- R2: The address splits into a 5-bit tag in bits 15:11, a 7-bit line index in bits 10:4, and a 4-bit word offset in bits 3:0. Memory block j (address bits 15:4) can live only in line j mod 128. Two blocks with the same index but different tags evict each other.
- R3: A read hit raises `cpu_ready` in the first cycle of the request, with the addressed word on `cpu_rdata`. It issues no memory transfer.
- R4: On a read miss the whole 16-word block is fetched at offsets 0 to 15 in ascending order. The requested word is returned in the cycle after the last fill word. The other 15 words of that block then hit.
- R5: In write-through mode (`WRITE_BACK`=0), every write makes exactly one memory write of the same address and data. `cpu_ready` is high in the cycle the memory accepts it. A write hit also updates the cached word. A write miss allocates no line.
- R6: In write-back mode (`WRITE_BACK`=1), a write hit completes in its first cycle. It updates only the cache, sets the line's dirty flag, and makes no memory transfer.
- R7: In write-back mode, a write miss first fills the block from memory and then writes the addressed word into the cache, leaving the line dirty.
- R8: In write-back mode, a miss on a line holding a dirty block first writes its 16 words back to that block's addresses, offsets 0 to 15 in order. The refill starts only after that.
- R9: An invalidate pulse carries a 12-bit block address, {tag, index}. It clears the valid flag of the indexed line if that exact block is resident. A pulse naming a block that is not resident changes nothing.
- R10: `mem_req` stays high with a stable `mem_addr` and `mem_we` until `mem_ready` is high. One word moves in each cycle where both are high.
- R11: `cpu_ready` stays low from miss detection until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access pending; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` on a read |
| cpu_ready | output | 1 | Access completes at this edge |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current word |
| inv_req | input | 1 | Invalidate pulse |
| inv_block | input | 12 | Block address {tag, index} to invalidate |

## Verification
The hardest state to reach is a dirty victim colliding with a new block. It needs the following sequence on one line index:
- a write that leaves the line dirty;
- then an access with a different tag on the same index.

The stimulus table arranges such pairs, including at the top address. It then reads the evicted words back, so that lost write-back data shows up as a wrong value.

Hits and misses are told apart from the completion time alone:
- 1 cycle for a hit;
- 33 cycles for a clean fill;
- 65 cycles for an eviction plus fill;
- 2 cycles for a write-through write.

These figures assume the bench memory answers every second cycle. A bench-side tag shadow predicts the expected time for each access. The invalidate case changes memory behind the cache before dropping the line, so that a stale hit would return the old word.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache.
// Assumes: used by dmc_ctrl and dm_cache only.
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // lookup; hits complete here
        ST_EVICT = 2'd1,   // copy dirty victim words to memory
        ST_FILL  = 2'd2,   // fetch missing block from memory
        ST_WTHRU = 2'd3    // single write-through memory write
    } ctrl_state_t;
endpackage

// File: rtl/dmc_tag_array.sv
// Per-line tag, valid and dirty storage with a combinational lookup.
// Assumes: fill_done and mark_dirty never target a line in the same cycle.
//          An invalidate that hits takes priority over a same-cycle update.
module dmc_tag_array #(
    parameter int TAG_W   = 5,
    parameter int INDEX_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic               lk_dirty,
    output logic [TAG_W-1:0]   lk_vtag,
    input  logic               fill_done,
    input  logic               mark_dirty,
    input  logic               inv_req,
    input  logic [INDEX_W-1:0] inv_index,
    input  logic [TAG_W-1:0]   inv_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic             inv_hit;

    // Lookup of the line the processor address selects
    always_comb begin
        lk_vtag  = tag_q[lk_index];
        lk_hit   = valid_q[lk_index] && (tag_q[lk_index] == lk_tag);
        lk_dirty = valid_q[lk_index] && dirty_q[lk_index];
        inv_hit  = inv_req && valid_q[inv_index] && (tag_q[inv_index] == inv_tag);
    end

    // Tag storage: written when a fill completes
    always_ff @(posedge clk) begin
        if (fill_done) tag_q[lk_index] <= lk_tag;
    end

    // Valid/dirty flags: reset clear, fill, dirty mark, invalidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_done) begin
                valid_q[lk_index] <= 1'b1;
                dirty_q[lk_index] <= 1'b0;
            end
            if (mark_dirty) dirty_q[lk_index] <= 1'b1;
            if (inv_hit) begin
                valid_q[inv_index] <= 1'b0;
                dirty_q[inv_index] <= 1'b0;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0 && dirty_q == '0));

    // R9
    inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_hit |=> !valid_q[$past(inv_index)]);

    // R6
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_dirty && !inv_hit) |=> dirty_q[$past(lk_index)]);
endmodule

// File: rtl/dmc_data_array.sv
// Word storage for all lines: one write port, one combinational read port.
// Assumes: address is {line index, word offset}.
module dmc_data_array #(
    parameter int DATA_W = 16,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Word write
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Word read
    always_comb rdata = mem_q[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
// Miss sequencer: decides hit/miss outcome and walks the word counter
// through eviction and fill bursts. WRITE_BACK picks the write policy.
// Assumes: the processor holds its request stable until cpu_ready.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int OFFSET_W   = 4,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic                lk_hit,
    input  logic                lk_dirty,
    input  logic                mem_ready,
    output ctrl_state_t         state,
    output logic [OFFSET_W-1:0] cnt,
    output logic                cpu_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic                fill_wr,
    output logic                cache_wr,
    output logic                fill_done,
    output logic                mark_dirty
);
    ctrl_state_t state_q, state_d;
    logic [OFFSET_W-1:0] cnt_q;
    logic last;

    assign state = state_q;
    assign cnt   = cnt_q;
    assign last  = (cnt_q == {OFFSET_W{1'b1}});

    // Next state and per-state outputs
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        fill_wr    = 1'b0;
        cache_wr   = 1'b0;
        fill_done  = 1'b0;
        mark_dirty = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!WRITE_BACK && cpu_we) begin
                        state_d = ST_WTHRU;
                    end else if (lk_hit) begin
                        cpu_ready  = 1'b1;
                        cache_wr   = cpu_we;
                        mark_dirty = cpu_we;
                    end else if (WRITE_BACK && lk_dirty) begin
                        state_d = ST_EVICT;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready && last) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    fill_wr = 1'b1;
                    if (last) begin
                        fill_done = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    cache_wr  = lk_hit;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst word counter: advances per accepted word, wraps to 0 at burst end
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if ((state_q == ST_EVICT || state_q == ST_FILL) && mem_ready)
            cnt_q <= cnt_q + 1'b1;
    end

    // R8
    evict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ready && !last)
            |=> (state_q == ST_EVICT && cnt_q == $past(cnt_q) + 1'b1));

    // R4
    fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ready && last) |=> (state_q == ST_IDLE && cnt_q == '0));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT || state_q == ST_FILL) |-> !cpu_ready);
endmodule

// File: rtl/dm_cache.sv
// Direct-mapped cache top: address split, memory address/data muxing and
// wiring of tag array, data array and miss sequencer.
// Assumes: processor holds address/data/we while cpu_req is high and
//          cpu_ready is low; memory holds nothing between handshakes.
module dm_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int INDEX_W    = 7,
    parameter int OFFSET_W   = 4,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        cpu_ready,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_ready,
    input  logic                        inv_req,
    input  logic [ADDR_W-OFFSET_W-1:0]  inv_block
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
    localparam int AW    = INDEX_W + OFFSET_W;

    logic [TAG_W-1:0]    cpu_tag, vtag, inv_tag;
    logic [INDEX_W-1:0]  cpu_index, inv_index;
    logic [OFFSET_W-1:0] cpu_off, cnt;
    logic                hit, vdirty, fill_wr, cache_wr, fill_done, mark_dirty;
    logic                arr_we;
    logic [AW-1:0]       arr_waddr, arr_raddr;
    logic [DATA_W-1:0]   arr_wdata, arr_rdata;
    ctrl_state_t         state;

    // Address fields of processor and invalidate requests
    always_comb begin
        cpu_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
        cpu_index = cpu_addr[OFFSET_W +: INDEX_W];
        cpu_off   = cpu_addr[OFFSET_W-1:0];
        inv_tag   = inv_block[INDEX_W +: TAG_W];
        inv_index = inv_block[INDEX_W-1:0];
    end

    dmc_tag_array #(.TAG_W(TAG_W), .INDEX_W(INDEX_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_index  (cpu_index),
        .lk_tag    (cpu_tag),
        .lk_hit    (hit),
        .lk_dirty  (vdirty),
        .lk_vtag   (vtag),
        .fill_done (fill_done),
        .mark_dirty(mark_dirty),
        .inv_req   (inv_req),
        .inv_index (inv_index),
        .inv_tag   (inv_tag)
    );

    dmc_ctrl #(.OFFSET_W(OFFSET_W), .WRITE_BACK(WRITE_BACK)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .lk_hit    (hit),
        .lk_dirty  (vdirty),
        .mem_ready (mem_ready),
        .state     (state),
        .cnt       (cnt),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .fill_wr   (fill_wr),
        .cache_wr  (cache_wr),
        .fill_done (fill_done),
        .mark_dirty(mark_dirty)
    );

    // Data array port selection: fill beats vs processor writes, evict reads
    always_comb begin
        arr_we    = fill_wr || cache_wr;
        arr_waddr = fill_wr ? {cpu_index, cnt} : {cpu_index, cpu_off};
        arr_wdata = fill_wr ? mem_rdata : cpu_wdata;
        arr_raddr = (state == ST_EVICT) ? {cpu_index, cnt} : {cpu_index, cpu_off};
        cpu_rdata = arr_rdata;
    end

    dmc_data_array #(.DATA_W(DATA_W), .AW(AW)) u_data (
        .clk  (clk),
        .we   (arr_we),
        .waddr(arr_waddr),
        .wdata(arr_wdata),
        .raddr(arr_raddr),
        .rdata(arr_rdata)
    );

    // Memory address and write data per sequencer state
    always_comb begin
        case (state)
            ST_EVICT: begin
                mem_addr  = {vtag, cpu_index, cnt};
                mem_wdata = arr_rdata;
            end
            ST_FILL: begin
                mem_addr  = {cpu_tag, cpu_index, cnt};
                mem_wdata = cpu_wdata;
            end
            default: begin
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
            end
        endcase
    end

    // R3
    read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we) |-> (hit && !mem_req));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !cpu_ready);

    generate
        if (!WRITE_BACK) begin : g_wt_chk
            // R5
            wt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_req && cpu_we && cpu_ready)
                    |-> (mem_req && mem_we && mem_ready &&
                         mem_addr == cpu_addr && mem_wdata == cpu_wdata));
        end
    endgenerate
endmodule

// File: tb/dm_cache_tb.sv
module dm_cache_tb;
    localparam int HCLK = 4;  // 125 MHz: 8 ns period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(HCLK) clk = ~clk;

    // Signals for write-back (b_) and write-through (t_) instances
    logic        b_req = 0, b_we = 0, b_ready, b_mreq, b_mwe, b_mready = 0;
    logic [15:0] b_addr = 0, b_wdata = 0, b_rdata, b_maddr, b_mwdata, b_mrdata = 0;
    logic        t_req = 0, t_we = 0, t_ready, t_mreq, t_mwe, t_mready = 0;
    logic [15:0] t_addr = 0, t_wdata = 0, t_rdata, t_maddr, t_mwdata, t_mrdata = 0;
    logic        inv_req = 0;
    logic [11:0] inv_block = 0;

    dm_cache #(.WRITE_BACK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(b_addr),
        .cpu_wdata(b_wdata), .cpu_rdata(b_rdata), .cpu_ready(b_ready),
        .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwdata),
        .mem_rdata(b_mrdata), .mem_ready(b_mready), .inv_req(inv_req), .inv_block(inv_block));

    dm_cache #(.WRITE_BACK(1'b0)) u_dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(t_req), .cpu_we(t_we), .cpu_addr(t_addr),
        .cpu_wdata(t_wdata), .cpu_rdata(t_rdata), .cpu_ready(t_ready),
        .mem_req(t_mreq), .mem_we(t_mwe), .mem_addr(t_maddr), .mem_wdata(t_mwdata),
        .mem_rdata(t_mrdata), .mem_ready(t_mready), .inv_req(inv_req), .inv_block(inv_block));

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 40503) ^ 16'h5A5A;
    endfunction

    // Memory models: one word per two cycles, content = init_word unless written
    logic [15:0] memb [int];
    logic [15:0] memt [int];
    int b_wr = 0, t_wr = 0;

    always @(negedge clk) begin
        if (b_mreq && !b_mready) begin
            b_mready <= 1'b1;
            if (b_mwe) begin memb[int'(b_maddr)] = b_mwdata; b_wr++; end
            else b_mrdata <= memb.exists(int'(b_maddr)) ? memb[int'(b_maddr)] : init_word(int'(b_maddr));
        end else b_mready <= 1'b0;
    end

    always @(negedge clk) begin
        if (t_mreq && !t_mready) begin
            t_mready <= 1'b1;
            if (t_mwe) begin memt[int'(t_maddr)] = t_mwdata; t_wr++; end
            else t_mrdata <= memt.exists(int'(t_maddr)) ? memt[int'(t_maddr)] : init_word(int'(t_maddr));
        end else t_mready <= 1'b0;
    end

    // Processor-view shadow and per-instance tag shadows (index 0 = WB, 1 = WT)
    logic [15:0] shadow [int];
    int sh_tag [2][128];
    bit sh_v [2][128];
    bit sh_d [2][128];

    int n_chk = 0, n_bad = 0;
    bit hung = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [15:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(int'(a));
    endfunction

    // Expected completion cycles and memory writes from the requirements
    task automatic predict(input int wt, input bit we, input logic [15:0] a,
                           output int cyc, output int wrs);
        int idx, tg;
        bit hit;
        idx = int'(a[10:4]);
        tg  = int'(a[15:11]);
        hit = sh_v[wt][idx] && sh_tag[wt][idx] == tg;
        wrs = 0;
        if (wt == 1) begin
            if (we) begin cyc = 2; wrs = 1; end
            else if (hit) cyc = 1;
            else begin cyc = 33; sh_v[1][idx] = 1; sh_tag[1][idx] = tg; end
        end else begin
            if (hit) begin cyc = 1; if (we) sh_d[0][idx] = 1; end
            else begin
                cyc = sh_d[0][idx] ? 65 : 33;
                wrs = sh_d[0][idx] ? 16 : 0;
                sh_v[0][idx] = 1; sh_tag[0][idx] = tg; sh_d[0][idx] = we;
            end
        end
    endtask

    task automatic clear_shadow_tags();
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 128; i++) begin sh_v[w][i] = 0; sh_d[w][i] = 0; end
    endtask

    // One processor access on the selected instance; returns data and cycles
    task automatic access(input int wt, input bit we, input logic [15:0] a,
                          input logic [15:0] wd, output logic [15:0] rd, output int cyc);
        bit rdy;
        @(negedge clk);
        if (wt == 1) begin t_req = 1; t_we = we; t_addr = a; t_wdata = wd; end
        else         begin b_req = 1; b_we = we; b_addr = a; b_wdata = wd; end
        cyc = 0; rd = '0;
        forever begin
            #1;
            cyc++;
            rdy = (wt == 1) ? t_ready : b_ready;
            if (rdy) begin rd = (wt == 1) ? t_rdata : b_rdata; break; end
            if (cyc > 300) begin hung = 1; break; end
            @(negedge clk);
        end
        @(negedge clk);
        if (wt == 1) t_req = 0; else b_req = 0;
    endtask

    // Apply one access to both instances and check data, timing and memory writes
    task automatic run_both(input bit we, input logic [15:0] a, input logic [15:0] wd,
                            input string req);
        logic [15:0] rd;
        int cyc, ecyc, ewr, w0;
        logic [15:0] ev;
        ev = exp_word(a);
        for (int wt = 0; wt < 2; wt++) begin
            w0 = (wt == 1) ? t_wr : b_wr;
            predict(wt, we, a, ecyc, ewr);
            access(wt, we, a, wd, rd, cyc);
            chk(cyc == ecyc, $sformatf("%s cycles wt=%0d addr=%h", req, wt, a), cyc, ecyc);
            chk((((wt == 1) ? t_wr : b_wr) - w0) == ewr,
                $sformatf("%s memwrites wt=%0d addr=%h", req, wt, a),
                ((wt == 1) ? t_wr : b_wr) - w0, ewr);
            if (!we) chk(rd == ev, $sformatf("%s rdata wt=%0d addr=%h", req, wt, a), rd, ev);
        end
        if (we) shadow[int'(a)] = wd;
    endtask

    task automatic invalidate(input logic [11:0] blk);
        @(negedge clk);
        inv_req = 1; inv_block = blk;
        @(negedge clk);
        inv_req = 0;
        for (int w = 0; w < 2; w++)
            if (sh_v[w][blk[6:0]] && sh_tag[w][blk[6:0]] == int'(blk[11:7])) begin
                sh_v[w][blk[6:0]] = 0; sh_d[w][blk[6:0]] = 0;
            end
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wdata;
    } vec_t;

    // R2..R8 stimulus; expectations come from the shadows
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0123, 16'h0000},  // R4 read miss
        '{1'b0, 16'h0125, 16'h0000},  // R3 read hit same line
        '{1'b1, 16'h0127, 16'hBEEF},  // R6 / R5 write hit
        '{1'b0, 16'h0127, 16'h0000},  // R3 written word
        '{1'b0, 16'h0923, 16'h0000},  // R2 R8 conflict, dirty victim in WB
        '{1'b0, 16'h0127, 16'h0000},  // R8 evicted data came back
        '{1'b1, 16'h4560, 16'h1357},  // R7 / R5 write miss
        '{1'b0, 16'h4560, 16'h0000},  // R7 allocated vs R5 not
        '{1'b1, 16'hFFFF, 16'hA5A5},  // R7 top address
        '{1'b0, 16'hFFFF, 16'h0000},
        '{1'b0, 16'h07FF, 16'h0000},  // R8 dirty top line evicted
        '{1'b0, 16'hFFF0, 16'h0000},  // R8 refetch after write-back
        '{1'b1, 16'h0923, 16'h2468},  // R5 R6 write
        '{1'b0, 16'h0923, 16'h0000}
    };

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        hung = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int cyc;
        clear_shadow_tags();

        // R1 reset state
        repeat (4) @(negedge clk);
        chk(!b_ready && !t_ready, "R1 ready low in reset", b_ready, 0);
        chk(!b_mreq && !t_mreq, "R1 mem_req low in reset", b_mreq, 0);
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        #1;
        chk(!b_ready && !t_ready && !b_mreq && !t_mreq, "R1 idle after reset", b_ready, 0);

        // R4 whole-line fill: first word misses, every other word then hits
        run_both(1'b0, 16'h2000, 16'h0, "R4");
        for (int o = 1; o < 16; o++) run_both(1'b0, 16'h2000 | 16'(o), 16'h0, "R4 line word");

        // R1 reset clears valid flags: resident line misses again
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        clear_shadow_tags();
        run_both(1'b0, 16'h2005, 16'h0, "R1 miss after reset");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (hung) break;
            run_both(VECS[i].we, VECS[i].addr, VECS[i].wdata, $sformatf("R2-table[%0d]", i));
        end

        // R9 invalidate
        run_both(1'b0, 16'h3000, 16'h0, "R9 setup");
        invalidate(12'h380);                       // same index, other tag: ignored
        run_both(1'b0, 16'h3001, 16'h0, "R9 non-matching ignored");
        memb[16'h3004] = 16'h1234;                 // external update behind the cache
        memt[16'h3004] = 16'h1234;
        shadow[16'h3004] = 16'h1234;
        invalidate(12'h300);
        run_both(1'b0, 16'h3004, 16'h0, "R9 refetch after invalidate");

        if (hung) begin
            n_chk++; n_bad++;
            $display("FAIL access hung actual=1 expected=0");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule